// File: doc/BRIEF.md
# Sequential Shift-Subtract Unsigned Divider

This block divides one W-bit unsigned numerator by one W-bit unsigned denominator and produces a W-bit quotient and a W-bit remainder. It works serially, consuming one numerator bit per clock cycle, starting from the most significant bit. Each step moves one numerator bit into a partial remainder. If the denominator fits, it is subtracted and a 1 enters the quotient; if not, a 0 enters and the partial remainder is kept. Two counters control the run. One counts the numerator bits still to be consumed and the other counts the remainder bits already produced. Their sum is always W, and the run ends when the first counter reaches zero.

Operands are given with a single-cycle `start` strobe. No valid/ready stream is used. The block is accepting exactly when `busy` is low, so `!busy` acts as the ready signal. A `start` seen while `busy` is high is dropped; it is not queued or held. The caller must keep `start` high in a cycle where `busy` is low. After a result is signalled it stays on the outputs until the next accepted `start`.

Top module: `seq_divider`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done`, `quotient` and `remainder` are all 0 until a `start` is accepted.
- R2: A `start` sampled high at a rising edge while `busy` is low is accepted. `numerator` and `denominator` are captured at that edge, and `busy` reads 1 after it.
- R3: A `start` sampled while `busy` is high has no effect. The run in progress completes with its original operands and its original timing.
- R4: For a nonzero denominator, the finished result has `quotient` = floor(n/d) and `remainder` = n mod d. Equivalently, n = d*q + r with r < d.
- R5: `done` goes high exactly W+1 rising edges after the edge that accepted `start`, counting the accepting edge. `busy` is high in every cycle between those two edges.
- R6: `done` is high for exactly one cycle, and `busy` is low in that cycle. `quotient` and `remainder` keep their values after `done` until the next accepted `start`.
- R7: For a zero denominator, the result has a `quotient` of all ones and a `remainder` equal to the numerator. The latency is the same as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; honoured only while busy is low |
| numerator | input | W | Dividend, captured on an accepted start |
| denominator | input | W | Divisor, captured on an accepted start |
| quotient | output | W | Quotient; valid from the done cycle until the next start |
| remainder | output | W | Remainder; valid from the done cycle until the next start |
| busy | output | 1 | High while a division is running |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Random operand pairs exercise the compare-and-subtract decision in both directions across all bit positions. Directed cases cover specific edges. A numerator below the denominator must give a zero quotient. A denominator of 1 or of the full-scale value tests the extreme quotients. Equal operands test the boundary of the greater-or-equal compare. A zero denominator tests the fall-through path that yields all ones. One run receives a second `start` in the middle with different operands; its result and latency show whether the captured operands or the step counters were disturbed.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
  // Width of a counter that must hold values 0..w inclusive.
  function automatic int cnt_width(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/div_step.sv
// One restoring step: shift a numerator bit into the partial remainder,
// then subtract the denominator when it fits.
module div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_in,
  input  logic         num_bit,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic         q_bit
);
  localparam int CW = W + 1;

  logic [CW-1:0] cand;
  logic [CW-1:0] diff;
  logic          unused_diff_top;

  always_comb begin
    cand  = {rem_in, num_bit};
    q_bit = (cand >= {1'b0, den});
    diff  = cand - {1'b0, den};
    rem_out = q_bit ? diff[W-1:0] : cand[W-1:0];
  end

  // The top bit of the difference is zero whenever the subtract is taken.
  assign unused_diff_top = diff[CW-1];
endmodule

// File: rtl/div_counters.sv
// Tracks bits left to consume and bits produced; their sum is always W.
module div_counters #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  output logic [CW-1:0] left_cnt,
  output logic [CW-1:0] made_cnt,
  output logic          last_step
);
  localparam logic [CW-1:0] FULL = CW'(W);
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_cnt <= '0;
      made_cnt <= FULL;
    end else if (load) begin
      left_cnt <= FULL;
      made_cnt <= '0;
    end else if (step) begin
      left_cnt <= left_cnt - ONE;
      made_cnt <= made_cnt + ONE;
    end
  end

  assign last_step = (left_cnt == ONE);

  AST_CNT_SUM: assert property (@(posedge clk) disable iff (rst)
    (left_cnt + made_cnt) == FULL); // R5
  AST_NO_STEP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    step |-> (left_cnt != '0)); // R5
endmodule

// File: rtl/seq_divider.sv
// Serial unsigned divider, one numerator bit per cycle, MSB first. W >= 2.
module seq_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] numerator,
  input  logic [W-1:0] denominator,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         busy,
  output logic         done
);
  import seqdiv_pkg::*;

  localparam int CW = cnt_width(W);
  localparam int PW = 2 * W;

  logic [W-1:0]  num_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  quot_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  rem_next;
  logic          q_bit;
  logic [CW-1:0] left_cnt;
  logic [CW-1:0] made_cnt;
  logic [CW-1:0] bit_idx;
  logic          last_step;
  logic          accept;

  assign accept  = start && !busy;
  assign bit_idx = left_cnt - CW'(1);

  div_counters #(.W(W), .CW(CW)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .step      (busy),
    .left_cnt  (left_cnt),
    .made_cnt  (made_cnt),
    .last_step (last_step)
  );

  div_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .num_bit (num_q[bit_idx]),
    .den     (den_q),
    .rem_out (rem_next),
    .q_bit   (q_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      num_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        num_q  <= numerator;
        den_q  <= denominator;
        quot_q <= '0;
        rem_q  <= '0;
      end else if (busy) begin
        quot_q <= {quot_q[W-2:0], q_bit};
        rem_q  <= rem_next;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quot_q;
  assign remainder = rem_q;

  AST_DIV_INVARIANT: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((PW'(num_q) >> left_cnt) == (PW'(den_q) * PW'(quot_q) + PW'(rem_q)))); // R4
  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (busy && den_q != '0) |-> (rem_q < den_q)); // R4
  AST_QUOT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((quot_q >> made_cnt) == '0)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(num_q) && $stable(den_q))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_ZERO_DEN: assert property (@(posedge clk) disable iff (rst)
    (done && den_q == '0) |-> (quot_q == '1 && rem_q == num_q)); // R7
endmodule

// File: tb/seq_divider_tb.sv
`timescale 1ns/1ps
module seq_divider_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [W-1:0] numerator;
  logic [W-1:0] denominator;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         busy;
  logic         done;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  seq_divider #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .numerator(numerator), .denominator(denominator),
    .quotient(quotient), .remainder(remainder),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_quot(input logic [W-1:0] n, input logic [W-1:0] d);
    return (d == 0) ? '1 : n / d;
  endfunction

  function automatic logic [W-1:0] exp_rem(input logic [W-1:0] n, input logic [W-1:0] d);
    return (d == 0) ? n : n % d;
  endfunction

  task automatic run_div(input logic [W-1:0] n, input logic [W-1:0] d, input bit inject);
    int lat;
    logic [W-1:0] eq, er;
    string rq;
    eq = exp_quot(n, d);
    er = exp_rem(n, d);
    @(negedge clk);
    start = 1'b1; numerator = n; denominator = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; numerator = ~n; denominator = d + 8'd3;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    lat = 1;
    while (!done && lat <= W + 4) begin
      if (inject && lat == 3) start = 1'b1;   // R3: start while busy
      if (inject && lat == 4) start = 1'b0;
      if (lat < W + 1) check(busy == 1'b1, "R5", "busy during run", busy, 1);
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    check(lat == W + 1, "R5", "latency", lat, W + 1);
    check(busy == 1'b0, "R6", "busy low at done", busy, 0);
    rq = (d == 0) ? "R7" : (inject ? "R3" : "R4");
    check(quotient == eq, rq, "quotient", quotient, eq);
    check(remainder == er, rq, "remainder", remainder, er);
    if (d != 0) begin
      check((int'(d) * int'(quotient) + int'(remainder)) == int'(n) && remainder < d,
            "R4", "n=d*q+r, r<d", int'(d) * int'(quotient) + int'(remainder), int'(n));
    end
    @(negedge clk);
    check(done == 1'b0, "R6", "done one cycle", done, 0);
    check(quotient == eq && remainder == er, "R6", "result held", quotient, eq);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; numerator = '0; denominator = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", "flags in reset", {busy, done}, 0);
    check(quotient == 0 && remainder == 0, "R1", "results in reset", quotient, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0 && remainder == 0,
          "R1", "idle after reset", {busy, done, quotient, remainder}, 0);

    // Directed corners
    run_div(8'd0,   8'd1,   1'b0);
    run_div(8'd255, 8'd1,   1'b0);
    run_div(8'd255, 8'd255, 1'b0);
    run_div(8'd77,  8'd77,  1'b0);
    run_div(8'd5,   8'd7,   1'b0);
    run_div(8'd254, 8'd255, 1'b0);
    run_div(8'd200, 8'd128, 1'b0);
    run_div(8'd255, 8'd2,   1'b0);
    run_div(8'd123, 8'd0,   1'b0);
    run_div(8'd255, 8'd0,   1'b0);
    run_div(8'd0,   8'd0,   1'b0);
    run_div(8'd200, 8'd9,   1'b1);
    run_div(8'd17,  8'd200, 1'b1);

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] n, d;
      n = W'($urandom);
      d = W'($urandom);
      if (i % 5 == 0) d = W'($urandom_range(1, 15));
      if (i % 37 == 0) d = '0;
      run_div(n, d, (i % 11) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule